// File: doc/BRIEF.md
# Host Command Packet Dispatcher

This block receives one host command packet at a time as a byte stream. The first byte is the command code and the bytes after it are its arguments. It decodes the command, checks the argument count and values, carries out the action, and returns a response packet as a byte stream. The actions are: reading and loading a 32-bit seconds clock, raising one-cycle power-off and system-restart requests to the system, writing the peripheral autopoll settings (enable, period, device mask), and two commands that are only acknowledged.

The seconds clock counts from midnight on 1 January 1904. It advances on a once-per-second tick input. The bytes of a packet are accepted while `inReady` is high. After the last byte, the input side closes until the whole response has left on `outByte`, at one byte per cycle.

Top module: `cmd_dispatch`

## Requirements
- R1: A command that is recognised and has valid arguments answers with 0x01, 0x00, the echoed command byte, and then any result bytes.
- R2: An unknown command byte answers with exactly four bytes: 0x02, 0x02, 0x01, the command byte.
- R3: A recognised command with a wrong argument count, or an autopoll period of zero, answers 0x02, 0x05, 0x01, the command byte, and has no other effect. Exact argument counts are: 0x01→1, 0x14→1, 0x19→2, 0x0A→0, 0x11→0, 0x13→1, 0x21→1, 0x03→0, 0x09→4. Packets with more arguments than the store holds count as a wrong count.
- R4: Get-time (0x03) answers with seven bytes: the success header and then the seconds value, most significant byte first.
- R5: Set-time (0x09) loads the four argument bytes (most significant first) into the seconds clock. Later ticks continue from that value and wrap from 0xFFFFFFFF to 0.
- R6: After reset, the seconds clock holds 2082844800 (0x7C25B080), which is the 1970 epoch expressed in the 1904 base. Each cycle with `secTick` high adds one.
- R7: Power-off (0x0A) and system-restart (0x11) each raise their request output for exactly one cycle, in the same cycle as the first byte of their success header.
- R8: The file-server-flag (0x13) and power-message (0x21) commands return a success header and change no output.
- R9: Autopoll enable (0x01) sets `pollEnable` to (argument ≠ 0). Set-period (0x14) loads `pollRateMs`. Set-device-list (0x19) loads `pollMask` with the first argument as the high byte.
- R10: `inReady` is low from the last packet byte until the last response byte. Bytes offered during that window are ignored. `outLast` marks the final byte, and `outValid` drops in the next cycle.
- R11: At reset, `inReady`=1, `outValid`=0, both request outputs are 0, `pollEnable`=0, `pollRateMs`=20 and `pollMask`=0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| inValid | input | 1 | Packet byte present |
| inByte | input | 8 | Packet byte (command first, then arguments) |
| inLast | input | 1 | Marks the final byte of the packet |
| inReady | output | 1 | Dispatcher accepts packet bytes |
| outValid | output | 1 | Response byte present |
| outByte | output | 8 | Response byte |
| outLast | output | 1 | Marks the final response byte |
| powerReq | output | 1 | One-cycle power-off request |
| resetReq | output | 1 | One-cycle system-restart request |
| pollEnable | output | 1 | Autopoll enable setting |
| pollRateMs | output | 8 | Autopoll period in milliseconds |
| pollMask | output | 16 | Autopoll device mask |

## Verification
The hardest state to reach from the ports is a packet byte that arrives while a response is still going out. A correct host never sends one. The bench deliberately offers a complete one-byte unknown command while a get-time answer is streaming, then checks that exactly seven bytes appear and that no error packet follows. The clock wrap is reached by loading 0xFFFFFFFF through set-time and giving a single tick. Packets longer than the argument store are sent to show that the saturating count still reports bad parameters.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_EXEC,
    ST_SEND
  } ctrlState_t;

  typedef struct packed {
    logic captureCmd;
    logic captureArg;
    logic execute;
    logic advance;
  } dpStrobe_t;

  localparam logic [7:0] PKT_PSEUDO  = 8'h01;
  localparam logic [7:0] PKT_ERROR   = 8'h02;
  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [7:0] ERR_BADARG  = 8'h05;

  localparam logic [7:0] CMD_AUTOPOLL = 8'h01;
  localparam logic [7:0] CMD_GETTIME  = 8'h03;
  localparam logic [7:0] CMD_SETTIME  = 8'h09;
  localparam logic [7:0] CMD_POWEROFF = 8'h0A;
  localparam logic [7:0] CMD_RESTART  = 8'h11;
  localparam logic [7:0] CMD_FSFLAG   = 8'h13;
  localparam logic [7:0] CMD_PERIOD   = 8'h14;
  localparam logic [7:0] CMD_DEVLIST  = 8'h19;
  localparam logic [7:0] CMD_PWRMSG   = 8'h21;

endpackage

// File: rtl/cmd_dispatch_ctrl.sv
module cmd_dispatch_ctrl
  import cmd_dispatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       respLast,
  output dpStrobe_t  strobe,
  output logic       inReady,
  output logic       outValid
);

  ctrlState_t state, stateNext;
  logic accept;

  always_comb begin
    inReady  = (state == ST_IDLE) || (state == ST_COLLECT);
    outValid = (state == ST_SEND);
    accept   = inReady && inValid;
    strobe.captureCmd = accept && (state == ST_IDLE);
    strobe.captureArg = accept && (state == ST_COLLECT);
    strobe.execute    = (state == ST_EXEC);
    strobe.advance    = (state == ST_SEND);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNext = inLast ? ST_EXEC : ST_COLLECT;
      ST_COLLECT: if (accept && inLast) stateNext = ST_EXEC;
      ST_EXEC:    stateNext = ST_SEND;
      ST_SEND:    if (respLast) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cmd_dispatch_dp.sv
module cmd_dispatch_dp
  import cmd_dispatch_pkg::*;
#(
  parameter int          MAX_ARGS      = 4,
  parameter logic [31:0] RESET_SECONDS = 32'd2082844800,
  parameter logic [7:0]  RATE_RESET    = 8'd20,
  parameter logic [15:0] MASK_RESET    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [7:0]  inByte,
  input  logic        secTick,
  output logic [7:0]  outByte,
  output logic        respLast,
  output logic        powerReq,
  output logic        resetReq,
  output logic        pollEnable,
  output logic [7:0]  pollRateMs,
  output logic [15:0] pollMask
);

  localparam int TIME_BYTES = 4;
  localparam int CNT_W      = $clog2(MAX_ARGS + 2);
  localparam int RESP_MAX   = 3 + TIME_BYTES;
  localparam int IDX_W      = $clog2(RESP_MAX);
  localparam int RESP_SLOTS = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_ARGS + 1);

  logic [7:0]       cmdReg;
  logic [7:0]       args [MAX_ARGS];
  logic [CNT_W-1:0] argCount;
  logic [31:0]      secCount;

  logic             known, argsOk, loadTime;
  logic [CNT_W-1:0] needArgs;

  logic             respErr;
  logic [7:0]       respCode;
  logic [7:0]       respCmd;
  logic [31:0]      respData;
  logic [IDX_W-1:0] respLastIdx;
  logic [IDX_W-1:0] idx;
  logic [7:0]       respBytes [RESP_SLOTS];

  // packet capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      argCount <= '0;
    end else if (strobe.captureCmd) begin
      cmdReg   <= inByte;
      argCount <= '0;
    end else if (strobe.captureArg && argCount != CNT_SAT) begin
      argCount <= argCount + 1'b1;
    end
  end

  for (genvar k = 0; k < MAX_ARGS; k++) begin : g_arg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) args[k] <= '0;
      else if (strobe.captureArg && argCount == CNT_W'(k)) args[k] <= inByte;
    end
  end

  // command decode
  always_comb begin
    known    = 1'b1;
    needArgs = '0;
    case (cmdReg)
      CMD_AUTOPOLL: needArgs = CNT_W'(1);
      CMD_PERIOD:   needArgs = CNT_W'(1);
      CMD_DEVLIST:  needArgs = CNT_W'(2);
      CMD_POWEROFF: needArgs = CNT_W'(0);
      CMD_RESTART:  needArgs = CNT_W'(0);
      CMD_FSFLAG:   needArgs = CNT_W'(1);
      CMD_PWRMSG:   needArgs = CNT_W'(1);
      CMD_GETTIME:  needArgs = CNT_W'(0);
      CMD_SETTIME:  needArgs = CNT_W'(TIME_BYTES);
      default:      known    = 1'b0;
    endcase
    argsOk   = known && (argCount == needArgs) &&
               !(cmdReg == CMD_PERIOD && args[0] == 8'h00);
    loadTime = strobe.execute && argsOk && (cmdReg == CMD_SETTIME);
  end

  // seconds clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         secCount <= RESET_SECONDS;
    else if (loadTime) secCount <= {args[0], args[1], args[2], args[3]};
    else if (secTick)  secCount <= secCount + 32'd1;
  end

  // actions and poll settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerReq   <= 1'b0;
      resetReq   <= 1'b0;
      pollEnable <= 1'b0;
      pollRateMs <= RATE_RESET;
      pollMask   <= MASK_RESET;
    end else begin
      powerReq <= 1'b0;
      resetReq <= 1'b0;
      if (strobe.execute && argsOk) begin
        case (cmdReg)
          CMD_POWEROFF: powerReq   <= 1'b1;
          CMD_RESTART:  resetReq   <= 1'b1;
          CMD_AUTOPOLL: pollEnable <= (args[0] != 8'h00);
          CMD_PERIOD:   pollRateMs <= args[0];
          CMD_DEVLIST:  pollMask   <= {args[0], args[1]};
          default: ;
        endcase
      end
    end
  end

  // response fields, latched in the execute cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respErr     <= 1'b0;
      respCode    <= '0;
      respCmd     <= '0;
      respData    <= '0;
      respLastIdx <= '0;
    end else if (strobe.execute) begin
      respErr  <= !argsOk;
      respCode <= known ? ERR_BADARG : ERR_UNKNOWN;
      respCmd  <= cmdReg;
      respData <= secCount;
      if (!argsOk)                    respLastIdx <= IDX_W'(3);
      else if (cmdReg == CMD_GETTIME) respLastIdx <= IDX_W'(RESP_MAX - 1);
      else                            respLastIdx <= IDX_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idx <= '0;
    else if (strobe.execute) idx <= '0;
    else if (strobe.advance) idx <= idx + 1'b1;
  end

  // response byte selection
  always_comb begin
    for (int k = 0; k < RESP_SLOTS; k++) respBytes[k] = 8'h00;
    if (respErr) begin
      respBytes[0] = PKT_ERROR;
      respBytes[1] = respCode;
      respBytes[2] = PKT_PSEUDO;
      respBytes[3] = respCmd;
    end else begin
      respBytes[0] = PKT_PSEUDO;
      respBytes[1] = 8'h00;
      respBytes[2] = respCmd;
      for (int k = 0; k < TIME_BYTES; k++)
        respBytes[3 + k] = respData[8*(TIME_BYTES-1-k) +: 8];
    end
  end

  assign outByte  = respBytes[idx];
  assign respLast = (idx == respLastIdx);

endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_dispatch_pkg::*;
#(
  parameter int          MAX_ARGS      = 4,
  parameter logic [31:0] RESET_SECONDS = 32'd2082844800,
  parameter logic [7:0]  RATE_RESET    = 8'd20,
  parameter logic [15:0] MASK_RESET    = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inLast,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outByte,
  output logic        outLast,
  output logic        powerReq,
  output logic        resetReq,
  output logic        pollEnable,
  output logic [7:0]  pollRateMs,
  output logic [15:0] pollMask
);

  dpStrobe_t strobe;
  logic      respLast;

  cmd_dispatch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .respLast (respLast),
    .strobe   (strobe),
    .inReady  (inReady),
    .outValid (outValid)
  );

  cmd_dispatch_dp #(
    .MAX_ARGS      (MAX_ARGS),
    .RESET_SECONDS (RESET_SECONDS),
    .RATE_RESET    (RATE_RESET),
    .MASK_RESET    (MASK_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inByte     (inByte),
    .secTick    (secTick),
    .outByte    (outByte),
    .respLast   (respLast),
    .powerReq   (powerReq),
    .resetReq   (resetReq),
    .pollEnable (pollEnable),
    .pollRateMs (pollRateMs),
    .pollMask   (pollMask)
  );

  assign outLast = outValid && respLast;

endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outByte,
  input logic       outLast,
  input logic       powerReq,
  input logic       resetReq
);

  a_r7_power_single: assert property (@(posedge clk) disable iff (!rstN)
    powerReq |=> !powerReq);

  a_r7_restart_single: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r7_pulse_with_header: assert property (@(posedge clk) disable iff (!rstN)
    (powerReq || resetReq) |-> (outValid && outByte == 8'h01));

  a_r7_requests_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({powerReq, resetReq}));

  a_r10_no_input_while_sending: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r10_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

  a_r10_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r1_first_byte_type: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outByte == 8'h01 || outByte == 8'h02));

endmodule

bind cmd_dispatch cmd_dispatch_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outByte  (outByte),
  .outLast  (outLast),
  .powerReq (powerReq),
  .resetReq (resetReq)
);

// File: tb/cmd_dispatch_test.sv
module cmd_dispatch_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inLast = 1'b0;
  logic        inReady, outValid, outLast, powerReq, resetReq, pollEnable;
  logic [7:0]  outByte, pollRateMs;
  logic [15:0] pollMask;

  always #10 clk = ~clk;

  cmd_dispatch uut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .inValid(inValid), .inByte(inByte), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outByte(outByte), .outLast(outLast),
    .powerReq(powerReq), .resetReq(resetReq),
    .pollEnable(pollEnable), .pollRateMs(pollRateMs), .pollMask(pollMask)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  logic [7:0] pkt [8];
  logic [7:0] ex  [8];
  logic [7:0] cap [16];
  int  capN = 0;
  bit  capDone = 0;
  int  pwrN = 0;
  int  rstPulseN = 0;
  bit  busySeen = 0;

  always @(negedge clk) begin
    if (outValid) begin
      if (capN < 16) cap[capN] = outByte;
      capN++;
      if (outLast) capDone = 1;
    end
    if (powerReq) pwrN++;
    if (resetReq) rstPulseN++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // send pkt[0..n-1]; optionally offer a stray packet while the answer streams
  task automatic sendPkt(input int n, input bit intrude);
    bit done = 0;
    int t = 0;
    @(posedge clk);
    capN = 0; capDone = 0; pwrN = 0; rstPulseN = 0; busySeen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1; inByte = pkt[i]; inLast = (i == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    while (!capDone && t < 50) begin
      @(negedge clk);
      t++;
      if (intrude && !done && outValid) begin
        busySeen = !inReady;
        inValid = 1'b1; inByte = 8'h55; inLast = 1'b1;
        @(negedge clk);
        inValid = 1'b0; inLast = 1'b0;
        done = 1;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chkResp(input string tag, input int n);
    chk({tag, " length"}, capN, n);
    for (int i = 0; i < n; i++) chk(tag, cap[i], ex[i]);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
  endtask

  task automatic getTime(input string tag, input logic [31:0] v);
    pkt[0] = 8'h03;
    sendPkt(1, 0);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'h03;
    ex[3] = v[31:24]; ex[4] = v[23:16]; ex[5] = v[15:8]; ex[6] = v[7:0];
    chkResp(tag, 7);
  endtask

  task automatic setTime(input logic [31:0] v);
    pkt[0] = 8'h09; pkt[1] = v[31:24]; pkt[2] = v[23:16]; pkt[3] = v[15:8]; pkt[4] = v[7:0];
    sendPkt(5, 0);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'h09;
    chkResp("R5 set header", 3);
  endtask

  task automatic expectErr(input string tag, input logic [7:0] code, input logic [7:0] cmd);
    ex[0] = 8'h02; ex[1] = code; ex[2] = 8'h01; ex[3] = cmd;
    chkResp(tag, 4);
  endtask

  task automatic testReset;
    chk("R11 inReady", inReady, 1);
    chk("R11 outValid", outValid, 0);
    chk("R11 powerReq", powerReq, 0);
    chk("R11 resetReq", resetReq, 0);
    chk("R11 pollEnable", pollEnable, 0);
    chk("R11 pollRateMs", pollRateMs, 20);
    chk("R11 pollMask", pollMask, 16'hFFFF);
  endtask

  task automatic testTimeBase;
    getTime("R6 R4 R1 reset time", 32'h7C25B080);
    tickN(5);
    getTime("R6 after five ticks", 32'h7C25B085);
  endtask

  task automatic testSetTime;
    setTime(32'h12345678);
    tickN(3);
    getTime("R5 load then count", 32'h1234567B);
    setTime(32'hFFFFFFFF);
    tickN(1);
    getTime("R5 wrap", 32'h00000000);
  endtask

  task automatic testUnknown;
    pkt[0] = 8'h55; pkt[1] = 8'h01;
    sendPkt(2, 0);
    expectErr("R2 unknown 0x55", 8'h02, 8'h55);
    pkt[0] = 8'h00;
    sendPkt(1, 0);
    expectErr("R2 unknown 0x00", 8'h02, 8'h00);
  endtask

  task automatic testBadArgs;
    pkt[0] = 8'h03; pkt[1] = 8'h00;
    sendPkt(2, 0);
    expectErr("R3 get-time extra arg", 8'h05, 8'h03);
    pkt[0] = 8'h14; pkt[1] = 8'h00;
    sendPkt(2, 0);
    expectErr("R3 zero period", 8'h05, 8'h14);
    chk("R3 period unchanged", pollRateMs, 20);
    pkt[0] = 8'h0A; pkt[1] = 8'h01;
    sendPkt(2, 0);
    expectErr("R3 power-off with arg", 8'h05, 8'h0A);
    chk("R3 no power pulse", pwrN, 0);
    for (int i = 0; i < 7; i++) pkt[i] = 8'h09 + 8'(i);
    pkt[0] = 8'h09;
    sendPkt(7, 0);
    expectErr("R3 over-long set-time", 8'h05, 8'h09);
    pkt[0] = 8'h19; pkt[1] = 8'hAB;
    sendPkt(2, 0);
    expectErr("R3 short device list", 8'h05, 8'h19);
    chk("R3 mask unchanged", pollMask, 16'hFFFF);
  endtask

  task automatic testRequests;
    pkt[0] = 8'h0A;
    sendPkt(1, 0);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'h0A;
    chkResp("R7 power-off header", 3);
    chk("R7 power pulse count", pwrN, 1);
    chk("R7 no restart pulse", rstPulseN, 0);
    pkt[0] = 8'h11;
    sendPkt(1, 0);
    ex[2] = 8'h11;
    chkResp("R7 restart header", 3);
    chk("R7 restart pulse count", rstPulseN, 1);
    chk("R7 no power pulse", pwrN, 0);
  endtask

  task automatic testAckOnly;
    pkt[0] = 8'h13; pkt[1] = 8'h01;
    sendPkt(2, 0);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'h13;
    chkResp("R8 file-server ack", 3);
    chk("R8 no pulses", pwrN + rstPulseN, 0);
    pkt[0] = 8'h21; pkt[1] = 8'h07;
    sendPkt(2, 0);
    ex[2] = 8'h21;
    chkResp("R8 power-message ack", 3);
    chk("R8 no pulses 2", pwrN + rstPulseN, 0);
    chk("R8 enable unchanged", pollEnable, 0);
    chk("R8 period unchanged", pollRateMs, 20);
    chk("R8 mask unchanged", pollMask, 16'hFFFF);
  endtask

  task automatic testPoll;
    pkt[0] = 8'h01; pkt[1] = 8'h07;
    sendPkt(2, 0);
    ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = 8'h01;
    chkResp("R9 R1 autopoll header", 3);
    chk("R9 enable on", pollEnable, 1);
    pkt[1] = 8'h00;
    sendPkt(2, 0);
    chk("R9 enable off", pollEnable, 0);
    pkt[0] = 8'h14; pkt[1] = 8'h0A;
    sendPkt(2, 0);
    chk("R9 period", pollRateMs, 10);
    pkt[0] = 8'h19; pkt[1] = 8'h12; pkt[2] = 8'h34;
    sendPkt(3, 0);
    chk("R9 mask", pollMask, 16'h1234);
  endtask

  task automatic testBusy;
    pkt[0] = 8'h03;
    sendPkt(1, 1);
    chk("R10 inReady low while sending", busySeen, 1);
    repeat (10) @(negedge clk);
    chk("R10 stray packet ignored", capN, 7);
    chk("R10 inReady back", inReady, 1);
    chk("R10 answer intact", cap[2], 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimeBase();
    testUnknown();
    testBadArgs();
    testRequests();
    testAckOnly();
    testPoll();
    testSetTime();
    testBusy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: run hung (R10) actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule